// File: doc/BRIEF.md
# Cascadable Synchronous Binary Up-Counter

This block is a nibble-wide synchronous up-counter built from rising-edge flip-flops. On each clock edge it clears to zero, loads a parallel value, counts up by one or holds. Clear and load act only at the next rising edge. A clear request beats a load request, and a load beats counting. A load works even while counting is disabled.

A carry output signals that the counter is at its top value (all ones) and that counting is enabled in the same cycle. Several instances can be chained into a wider counter. Each stage's carry drives the count enable of the next stage. Clear and load are shared across the stages, and each stage gets its own slice of the load value. The upper stage then advances exactly once per wrap of the lower stage. A lower stage that is stalled at all ones does not push the upper stage forward.

Top module: `sync_bin_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high, `clr` high at a rising edge makes the count 0 after that edge, even if `ld` and `cnt_en` are also high.
- R3: With `clr` low and `ld` high at a rising edge, the count takes `load_val` after that edge, with bit 3 as the most significant bit. This also happens while `cnt_en` is low.
- R4: With `clr` and `ld` low and `cnt_en` high, each rising edge adds one to the count modulo 16, so 15 wraps to 0.
- R5: With `clr`, `ld` and `cnt_en` all low, the count keeps its value across the edge.
- R6: `carry_o` is high in the same cycle exactly when `cnt_en` is high and the count is 15, that is, when all four bits are 1.
- R7: On a counting edge, bit 0 always flips, and bit i flips only when all bits below i are 1.
- R8: In a chain of two stages, the low stage's `carry_o` drives the high stage's `cnt_en`, and `clr` and `ld` are shared. The pair then counts as one 8-bit counter modulo 256, and the high stage holds while the low stage is not enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear request, active high |
| ld | input | 1 | Synchronous parallel load request, active high |
| cnt_en | input | 1 | Count enable, active high |
| load_val | input | 4 | Value taken by a load; bit 3 is the MSB |
| count_o | output | 4 | Current count |
| carry_o | output | 1 | High when the count is all ones and counting is enabled |

## Verification
Clear, load and counting can all be requested in the same cycle. The bench provokes this both in directed vectors and in random vectors, where each of `clr`, `ld` and `cnt_en` is drawn on its own. The reference model applies the fixed order: clear first, then load, then count. Every resulting count of the two chained stages is compared with that model. A second overlap also gets directed vectors: a stage sitting at all ones while its enable drops or while a load arrives. These check that the upper stage moves only when the carry is really high.

// File: rtl/sync_bin_counter_pkg.sv
// Package: shared definitions for the cascadable up-counter.
// Assumes: nothing beyond a single synchronous clock domain.
package sync_bin_counter_pkg;

    // Operation chosen for the next rising edge, after priority resolution.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_COUNT = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/sync_bin_counter_opsel.sv
// Module: sync_bin_counter_opsel
// Resolves the three control requests into one operation, in the fixed
// priority clear > load > count > hold.
// Assumes: the inputs are already synchronous to the counter clock.
module sync_bin_counter_opsel
    import sync_bin_counter_pkg::*;
(
    input  logic    clr,
    input  logic    ld,
    input  logic    cnt_en,
    output cnt_op_e op
);

    // Priority decode of the control requests.
    always_comb begin
        if (clr)         op = OP_CLEAR;
        else if (ld)     op = OP_LOAD;
        else if (cnt_en) op = OP_COUNT;
        else             op = OP_HOLD;
    end

    // R2/R3: a clear request always wins; a load beats counting.
    always_comb begin
        if (clr) assert_clear_wins_R2: assert (op == OP_CLEAR);
        if (!clr && ld) assert_load_beats_count_R3: assert (op == OP_LOAD);
    end

endmodule

// File: rtl/sync_bin_counter_tchain.sv
// Module: sync_bin_counter_tchain
// Builds the per-bit toggle enables of a synchronous binary counter.
// Bit 0 toggles whenever counting is enabled. Each higher bit toggles
// only when all lower bits are 1.
// Assumes: W >= 1.
module sync_bin_counter_tchain #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en,
    output logic [W-1:0] tog
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                // Lowest bit: toggles on every enabled count.
                assign tog[i] = en;
            end else begin : g_upper
                // Upper bit: toggles when every lower bit is 1.
                assign tog[i] = en & (&q[i-1:0]);
            end
        end
    endgenerate

    // R7: the set toggle bits always form a contiguous run from bit 0.
    always_comb begin
        assert_toggle_contiguous_R7: assert ((tog & (tog + 1'b1)) == '0);
    end

endmodule

// File: rtl/sync_bin_counter.sv
// Module: sync_bin_counter
// Nibble-wide synchronous up-counter with synchronous clear and parallel
// load, a count enable, and a carry output for building wider counters.
// Assumes: one clock, a synchronous active-low reset, and controls that
// meet setup and hold at the rising edge.
module sync_bin_counter
    import sync_bin_counter_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic             cnt_en,
    input  logic [NIB_W-1:0] load_val,
    output logic [NIB_W-1:0] count_o,
    output logic             carry_o
);

    localparam logic [NIB_W-1:0] ALL_ONES = {NIB_W{1'b1}};

    cnt_op_e          op;
    logic [NIB_W-1:0] cnt_q;
    logic [NIB_W-1:0] cnt_d;
    logic [NIB_W-1:0] tog;

    sync_bin_counter_opsel u_opsel (
        .clr    (clr),
        .ld     (ld),
        .cnt_en (cnt_en),
        .op     (op)
    );

    sync_bin_counter_tchain #(.W(NIB_W)) u_tchain (
        .q   (cnt_q),
        .en  (op == OP_COUNT),
        .tog (tog)
    );

    // Next-state selection for the chosen operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = load_val;
            OP_COUNT: cnt_d = cnt_q ^ tog;
            default:  cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Carry: top value while enabled, so a stalled stage does not ripple.
    assign carry_o = cnt_en & (cnt_q == ALL_ONES);
    assign count_o = cnt_q;

    // R1: the edge after reset leaves the count at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

    // R2: a clear leaves zero whatever else is requested.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R3: a load takes the parallel value, even with counting disabled.
    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (cnt_q == $past(load_val)));

    // R4: an enabled count adds one modulo 2**NIB_W.
    assert_count_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && cnt_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: with no request the value holds.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !cnt_en) |=> $stable(cnt_q));

    // R6: a carry with no override is followed by a wrap to zero.
    assert_carry_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_o && !clr && !ld) |=> (cnt_q == '0));

endmodule

// File: tb/sync_bin_counter_bench.sv
// Bench: two chained counter stages checked against an 8-bit model.
module sync_bin_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk;
    logic       rst_n;
    logic       clr;
    logic       ld;
    logic       en;
    logic [7:0] lv;
    logic [3:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic       carry_lo;
    logic       carry_hi;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 0;
    logic [7:0] model;

    sync_bin_counter u_sync_bin_counter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .cnt_en(en),
        .load_val(lv[3:0]), .count_o(cnt_lo), .carry_o(carry_lo)
    );

    sync_bin_counter u_sync_bin_counter_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .cnt_en(carry_lo),
        .load_val(lv[7:4]), .count_o(cnt_hi), .carry_o(carry_hi)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference next value: clear, then load, then count, else hold.
    function automatic logic [7:0] next_val(input logic [7:0] cur,
            input logic c, input logic l, input logic e, input logic [7:0] v);
        if (c)      return 8'h00;
        else if (l) return v;
        else if (e) return cur + 8'd1;
        else        return cur;
    endfunction

    // Bits expected to flip in a nibble on a counting edge.
    function automatic logic [3:0] flip_mask(input logic [3:0] q);
        logic [3:0] m;
        m[0] = 1'b1;
        for (int i = 1; i < 4; i++) m[i] = m[i-1] & q[i-1];
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One vector: drive at the falling edge, check carry, clock, check count.
    task automatic step(input logic c, input logic l, input logic e, input logic [7:0] v);
        logic [7:0] old;
        logic       ecl;
        logic       ech;
        clr = c; ld = l; en = e; lv = v;
        #1;
        ecl = e && (model[3:0] == 4'hF);
        ech = ecl && (model[7:4] == 4'hF);
        check(carry_lo == ecl, "R6 low carry", carry_lo, ecl);
        check(carry_hi == ech, "R8 high carry", carry_hi, ech);
        old   = model;
        model = next_val(model, c, l, e, v);
        @(posedge clk);
        @(negedge clk);
        if (c)      check({cnt_hi, cnt_lo} == model, "R2 clear", {cnt_hi, cnt_lo}, model);
        else if (l) check({cnt_hi, cnt_lo} == model, "R3 load", {cnt_hi, cnt_lo}, model);
        else if (e) begin
            check({cnt_hi, cnt_lo} == model, "R4/R8 count", {cnt_hi, cnt_lo}, model);
            check((old[3:0] ^ cnt_lo) == flip_mask(old[3:0]), "R7 toggles",
                  old[3:0] ^ cnt_lo, flip_mask(old[3:0]));
        end else
            check({cnt_hi, cnt_lo} == model, "R5/R8 hold", {cnt_hi, cnt_lo}, model);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0; clr = 1'b0; ld = 1'b1; en = 1'b1; lv = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset wins over a pending load and count.
        check({cnt_hi, cnt_lo} == 8'h00, "R1 reset", {cnt_hi, cnt_lo}, 0);
        model = 8'h00;
        rst_n = 1'b1;

        // R3: load with counting disabled; MSB is bit 3 of each nibble.
        step(1'b0, 1'b1, 1'b0, 8'h8E);
        // R2: clear beats load and count in the same cycle.
        step(1'b1, 1'b1, 1'b1, 8'h77);
        // R8: full wrap of the chained pair, every value checked.
        for (int k = 0; k < 260; k++) step(1'b0, 1'b0, 1'b1, 8'h00);
        // R6/R8: stall at 0x0F, no carry, upper nibble holds.
        step(1'b0, 1'b1, 1'b0, 8'h0F);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        // Load beats count while at all ones.
        step(1'b0, 1'b1, 1'b1, 8'h3C);
        // R4/R8: 0xFF wraps to 0x00.
        step(1'b0, 1'b1, 1'b0, 8'hFF);
        step(1'b0, 1'b0, 1'b1, 8'h00);
        // R2/R3/R4/R5: random mix of simultaneous requests.
        for (int k = 0; k < 3000; k++) begin
            logic c;
            logic l;
            logic e;
            logic [7:0] v;
            c = (($urandom % 16) == 0);
            l = (($urandom % 8) == 0);
            e = (($urandom % 4) != 0);
            v = 8'($urandom);
            step(c, l, e, v);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule